// File: doc/BRIEF.md
# Bit-Level Serial EEPROM Responder

This block behaves as a read-only 256-byte serial EEPROM on a two-wire bus driven by a bit-banged master. The master's clock and data levels do not reach the block as wires. They arrive as synchronous inputs, with a one-cycle strobe marking each new sample. Every strobe is handled as a single event. The block compares the previous clock and data levels with the new ones and classifies the event as a bus condition, a clock rise or a clock fall.

A tick counter decides what a clock rise means:
- The first eight bits after a START form the command byte.
- An acknowledge slot follows the command byte.
- The next eight bits form one of two things. For a write command they are the word address. For a read command they are the data byte, shifted out MSB first.
- The stored byte is then fetched and a second acknowledge slot is armed.

A random read is a write command with an address, then a repeated START and a read command. The array is filled through a separate preload port that is honoured only while the bus is idle.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset `sda_out` is 1 (released), `bus_err` is 0 and the block is idle.
- R2: Data falling while the clock is high in both the previous and the new sample is a START and begins a transaction. Data rising while the clock is high in both samples is a STOP. A STOP returns the block to idle with `sda_out` released and no acknowledge pending.
- R3: While idle, clock edges and data bits have no effect, and `sda_out` stays 1 until a START.
- R4: A bit is taken only on a clock rise (previous sample low, new sample high) whose data level matches the previous sample. The first eight such bits after a START form the command byte, MSB first. Bit 0 of the command selects read (1) or write (0).
- R5: After the eighth command bit, the next clock rise drives `sda_out` to 0 as acknowledge and does not count as a data bit.
- R6: For a write command, the next eight bits form the 8-bit word address, MSB first. After the eighth, the byte at that address is loaded and the following clock rise is acknowledged with `sda_out` 0.
- R7: For a read command, each of the next eight clock rises drives `sda_out` with the next bit of the loaded byte, MSB first. Each clock fall releases `sda_out` to 1.
- R8: A clock rise whose data level differs from the previous sample, during a transaction, pulses `bus_err` for one cycle and is not counted as a bit.
- R9: A preload write (`init_we`) stores `init_data` at `init_addr` only while idle. During a transaction it has no effect.
- R10: Once the load at the end of the second byte has happened, further bits are ignored and `sda_out` stays released on them, until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One-cycle strobe: new bus levels are present |
| scl_in | input | 1 | Sampled bus clock level |
| sda_in | input | 1 | Sampled bus data level driven by the master |
| init_we | input | 1 | Preload write enable |
| init_addr | input | 8 | Preload byte address |
| init_data | input | 8 | Preload byte value |
| sda_out | output | 1 | Data level driven by the responder (1 = released) |
| bus_err | output | 1 | One-cycle pulse: data changed on a clock rise |

## Verification
The bench clocks bits with no preceding START and expects no acknowledge. A design that leaves the idle gate open would answer them.

It places a data change on a clock rise just before a command byte and expects the acknowledge exactly eight bits later. A design that counts the bad bit acknowledges one bit early.

It reads the lowest and highest addresses, and it attempts a preload in the middle of a transaction. A design without the idle gate on the preload port would return the new byte instead of the old one.

It also clocks bits after the load point and expects `sda_out` to stay released, which catches a tick counter that wraps or keeps shifting.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [7:0]        init_data,
  output logic              sda_out,
  output logic              bus_err
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BYTE_W = 8;
  localparam int TICK_W = $clog2(2*BYTE_W + 2);
  localparam logic [TICK_W-1:0] T_FIRST   = TICK_W'(1);
  localparam logic [TICK_W-1:0] T_CMD_END = TICK_W'(BYTE_W + 1);
  localparam logic [TICK_W-1:0] T_LAST    = TICK_W'(2*BYTE_W);
  localparam logic [TICK_W-1:0] T_DONE    = TICK_W'(2*BYTE_W + 1);

  logic              prev_scl, prev_sda, ack_pend;
  logic [TICK_W-1:0] tick;
  logic [BYTE_W-1:0] cmd, data;
  logic [ADDR_W-1:0] waddr;
  logic [BYTE_W-1:0] mem [DEPTH];

  wire bus_cond = sample_stb & prev_scl & scl_in & (prev_sda != sda_in);
  wire idle     = (tick == '0) & ~ack_pend;
  wire rise     = sample_stb & ~prev_scl & scl_in;
  wire fall     = sample_stb & prev_scl & ~scl_in;
  wire bit_ok   = (prev_sda == sda_in);
  wire [ADDR_W-1:0] addr_next = {waddr[ADDR_W-2:0], sda_in};
  wire [ADDR_W-1:0] ld_addr   = cmd[0] ? waddr : addr_next;

  always_ff @(posedge clk) begin
    if (init_we && idle) mem[init_addr] <= init_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_scl <= 1'b1;
      prev_sda <= 1'b1;
      tick     <= '0;
      ack_pend <= 1'b0;
      cmd      <= '0;
      data     <= '0;
      waddr    <= '0;
      sda_out  <= 1'b1;
      bus_err  <= 1'b0;
    end else begin
      bus_err <= 1'b0;
      if (sample_stb) begin
        prev_scl <= scl_in;
        prev_sda <= sda_in;
      end
      if (bus_cond) begin
        tick     <= sda_in ? '0 : T_FIRST;
        ack_pend <= 1'b0;
        sda_out  <= 1'b1;
      end else if (!idle) begin
        if (rise) begin
          if (ack_pend) begin
            sda_out  <= 1'b0;
            ack_pend <= 1'b0;
          end else if (!bit_ok) begin
            bus_err <= 1'b1;
          end else if (tick < T_CMD_END) begin
            cmd  <= {cmd[BYTE_W-2:0], sda_in};
            tick <= tick + 1'b1;
            if (tick == T_CMD_END - 1'b1) ack_pend <= 1'b1;
          end else if (tick < T_DONE) begin
            if (cmd[0]) begin
              sda_out <= data[BYTE_W-1];
              data    <= {data[BYTE_W-2:0], 1'b0};
            end else begin
              waddr <= addr_next;
            end
            tick <= tick + 1'b1;
            if (tick == T_LAST) begin
              data     <= mem[ld_addr];
              ack_pend <= 1'b1;
            end
          end
        end else if (fall) begin
          sda_out <= 1'b1;
        end
      end
    end
  end

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cond && sda_in) |=> (idle && sda_out)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !bus_cond) |=> (idle && sda_out)); // R3
  AST_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && ack_pend) |=> (!sda_out && !ack_pend)); // R5
  AST_FALL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !idle) |=> sda_out); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(rise && !bit_ok && !idle && !ack_pend)); // R8
  AST_TICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick <= T_DONE)); // R10
endmodule

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, stb = 1'b0, scl = 1'b1, sda = 1'b1;
  logic init_we = 1'b0;
  logic [7:0] init_addr = '0, init_data = '0;
  logic sda_out, bus_err;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct { bit is_err; bit exp; string tag; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  i2c_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .sample_stb(stb), .scl_in(scl), .sda_in(sda),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data),
    .sda_out(sda_out), .bus_err(bus_err)
  );

  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      exp_t e;
      logic act;
      e = q.pop_front();
      act = e.is_err ? bus_err : sda_out;
      checks++;
      if (act !== e.exp) begin
        fails++;
        $display("FAIL %s: %s got %b expected %b", e.tag,
                 e.is_err ? "bus_err" : "sda_out", act, e.exp);
      end
    end
  end

  task automatic expect_v(input bit is_err, input bit v, input string tag);
    q.push_back('{is_err, v, tag});
  endtask

  task automatic step(input logic c, input logic d);
    @(negedge clk); scl = c; sda = d; stb = 1'b1;
    @(negedge clk); stb = 1'b0;
  endtask

  task automatic start_c(); step(0,1); step(1,1); step(1,0); step(0,0); endtask
  task automatic stop_c();  step(0,0); step(1,0); step(1,1); endtask
  task automatic put_bit(input logic b); step(0,b); step(1,b); step(0,b); endtask

  task automatic ack_slot(input string tag);
    step(0,1); step(1,1); expect_v(0, 1'b0, tag);
    step(0,1); expect_v(0, 1'b1, "R7");
  endtask

  task automatic send_byte(input logic [7:0] b, input string tag);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    ack_slot(tag);
  endtask

  task automatic read_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      step(0,1); step(1,1); expect_v(0, v[i], "R7");
      step(0,1); expect_v(0, 1'b1, "R7");
    end
  endtask

  task automatic init_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); init_we = 1'b1; init_addr = a; init_data = d;
    @(negedge clk); init_we = 1'b0;
  endtask

  task automatic rand_read(input logic [7:0] a, input logic [7:0] v);
    start_c();
    send_byte(8'hA0, "R4");
    send_byte(a, "R6");
    start_c();
    send_byte(8'hA1, "R5");
    read_byte(v);
    stop_c();
    expect_v(0, 1'b1, "R2");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_v(0, 1'b1, "R1");
    expect_v(1, 1'b0, "R1");

    // R9 preload while idle
    init_wr(8'h3C, 8'hA5);
    init_wr(8'h80, 8'h5A);
    init_wr(8'hFF, 8'h81);
    init_wr(8'h00, 8'h7E);

    // R3: bits with no START never acknowledged
    for (int i = 0; i < 10; i++) begin
      step(0,0); step(1,0); expect_v(0, 1'b1, "R3"); step(0,0);
    end

    rand_read(8'h3C, 8'hA5);
    rand_read(8'hFF, 8'h81);
    rand_read(8'h00, 8'h7E);

    // R2: STOP mid-command returns to idle; later bits unanswered
    start_c();
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    stop_c();
    for (int i = 0; i < 10; i++) begin
      step(0,1); step(1,1); expect_v(0, 1'b1, "R2"); step(0,1);
    end

    // R8: data change on clock rise flags error and is not counted
    start_c();
    step(1,1); expect_v(1, 1'b1, "R8");
    step(0,1); expect_v(1, 1'b0, "R8");
    send_byte(8'hA0, "R8");
    send_byte(8'h80, "R6");
    // R10: bits after the load point are ignored
    for (int i = 0; i < 5; i++) begin
      step(0,0); step(1,0); expect_v(0, 1'b1, "R10"); step(0,0);
    end
    start_c();
    send_byte(8'hA1, "R5");
    read_byte(8'h5A);
    stop_c();

    // R9: preload during a transaction is ignored
    start_c();
    send_byte(8'hA0, "R4");
    init_wr(8'h3C, 8'h11);
    send_byte(8'h3C, "R6");
    start_c();
    send_byte(8'hA1, "R5");
    read_byte(8'hA5);
    stop_c();
    expect_v(0, 1'b1, "R2");
    init_wr(8'h3C, 8'h11);
    rand_read(8'h3C, 8'h11);

    // R4: command bit 0 clear with other upper bits still selects write
    start_c();
    send_byte(8'h5E, "R4");
    send_byte(8'hFF, "R6");
    start_c();
    send_byte(8'h01, "R4");
    read_byte(8'h81);
    stop_c();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule